// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the register front end that software uses to program a set of DMA channels. Each channel owns an 8 KB window of 32-bit registers. The block decodes word accesses into that window and holds the descriptor, buffer, group and configuration pointers that the data engine runs from. Reads of the status word return the engine's reported state. Data movement itself stays in the engine; this block only stores, composes and signals.

Each channel keeps a raw interrupt register that engine events set. A mask selects which raw bits drive the channel's level interrupt line. Software clears raw bits through a write-one-to-clear acknowledge register, which always reads back as zero. A stream command register turns software writes into one-cycle pulses that ask the engine to load a data descriptor, load a context descriptor, or start. A write to the command register pulses a continue request. When the engine finishes a context load, it hands back a saved descriptor pointer and a saved buffer pointer, and these overwrite the pointer registers.

The bus side runs a small access state machine with three states. In BUS_IDLE it accepts a request; the transition IDLE→RESP_OK is taken for a legal access and IDLE→RESP_ERR for a narrow access or a channel out of range. From either response state the machine returns to BUS_IDLE after one cycle (RESP_OK→IDLE, RESP_ERR→IDLE).

Top module: `dma_chan_regfront`

## Requirements
- R1: The channel index is address bits [ADDR_W-1:13] and the register offset is bits [12:0]. A request is accepted only in BUS_IDLE, and exactly one response cycle (resp_valid high) follows each accepted request. An index of NUM_CH or more gets an error response.
- R2: These registers read back the value last written: config 0x84, command 0x80, stream command 0x9C, saved descriptor 0x58, buffer pointer 0x5C, group 0x60, group-down 0x7C. The mask at 0x8C holds its low INTR_W bits. Any other offset reads 0 and ignores writes.
- R3: Status at 0x88 reads engine state in bits [2:0] (0 reset, 2 stopped, 4 running), the engine eol flag in bit 5 and the command source in bits [8+SRC_W-1:8], with all other bits zero. Writes to it have no effect.
- R4: The channel enable output is config bit 0 AND the client-attached input. The stop output is config bit 1.
- R5: Writing the acknowledge register at 0x90 clears every raw bit written as one. The register reads 0. An engine set of the same bit in the same cycle wins over the clear.
- R6: Raw interrupt at 0x94 collects engine set pulses. Masked interrupt at 0x98 is raw AND mask. The irq line is high exactly when the masked value is nonzero, from the cycle after the edge that changes it.
- R7: A stream command write decodes only its low 10 bits. If bit 8 or bit 6 is set, a data-load pulse is given. If bit 5 is also set, a start pulse is given with it. If bit 9 is set, a context-load pulse is given. Each pulse lasts one cycle, the cycle after the write.
- R8: A context-update strobe from the engine loads the saved descriptor and buffer pointer registers, and it wins over a bus write in the same cycle.
- R9: Each write to the command register at 0x80 gives a one-cycle continue pulse in the following cycle.
- R10: An access whose byte enables are not all ones gets an error response, writes nothing and returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address: channel above bit 12, offset below |
| be_i | input | 4 | Byte enables; only 4'hF is legal |
| wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response cycle |
| resp_err_o | output | 1 | Error response |
| rdata_o | output | 32 | Read data, valid with resp_valid_o |
| client_attached_i | input | NUM_CH | Client present per channel |
| eng_state_i | input | NUM_CH*3 | Engine state per channel |
| eng_eol_i | input | NUM_CH | Engine end-of-list flag per channel |
| eng_src_i | input | NUM_CH*SRC_W | Stream command source per channel |
| intr_set_i | input | NUM_CH*INTR_W | Raw interrupt set pulses |
| ctx_upd_i | input | NUM_CH | Context load completed strobe |
| ctx_desc_i | input | NUM_CH*32 | Saved descriptor pointer from context |
| ctx_buf_i | input | NUM_CH*32 | Saved buffer pointer from context |
| chan_en_o | output | NUM_CH | Channel enabled |
| chan_stop_o | output | NUM_CH | Channel stop request |
| load_d_o | output | NUM_CH | Data-descriptor load pulse |
| load_c_o | output | NUM_CH | Context-descriptor load pulse |
| start_o | output | NUM_CH | Start pulse |
| cont_o | output | NUM_CH | Continue pulse |
| irq_o | output | NUM_CH | Level interrupt per channel |
| desc_o | output | NUM_CH*32 | Saved descriptor pointer |
| buf_o | output | NUM_CH*32 | Buffer pointer |
| grp_o | output | NUM_CH*32 | Group pointer |
| grp_down_o | output | NUM_CH*32 | Group-down pointer |

## Verification
A write takes effect at the edge that accepts it. The response, the read data, the stream and continue pulses, the new config outputs and the new irq level all appear in the cycle after that edge. A set pulse from the engine moves the raw register, and the irq line follows, one cycle after the edge that samples the pulse. The bench drives each access on a falling edge and checks the response, the pulses and irq on the next falling edge, which is the middle of the cycle where they are due. It samples once more a cycle later to confirm that the pulses have ended.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int OFS_W = 13;

    localparam logic [OFS_W-1:0] OFS_DESC   = 13'h058;
    localparam logic [OFS_W-1:0] OFS_BUF    = 13'h05C;
    localparam logic [OFS_W-1:0] OFS_GRP    = 13'h060;
    localparam logic [OFS_W-1:0] OFS_GRPDN  = 13'h07C;
    localparam logic [OFS_W-1:0] OFS_CMD    = 13'h080;
    localparam logic [OFS_W-1:0] OFS_CFG    = 13'h084;
    localparam logic [OFS_W-1:0] OFS_STAT   = 13'h088;
    localparam logic [OFS_W-1:0] OFS_IMASK  = 13'h08C;
    localparam logic [OFS_W-1:0] OFS_IACK   = 13'h090;
    localparam logic [OFS_W-1:0] OFS_IRAW   = 13'h094;
    localparam logic [OFS_W-1:0] OFS_IMSKD  = 13'h098;
    localparam logic [OFS_W-1:0] OFS_STRM   = 13'h09C;

    // stream command bit groups (low 10 bits only are decoded)
    localparam logic [9:0] STRM_LOAD_D = 10'h140;
    localparam int         STRM_BURST  = 5;
    localparam int         STRM_LOAD_C = 9;

    typedef enum logic [3:0] {
        REG_NONE, REG_DESC, REG_BUF, REG_GRP, REG_GRPDN, REG_CMD, REG_CFG,
        REG_STAT, REG_IMASK, REG_IACK, REG_IRAW, REG_IMSKD, REG_STRM
    } reg_sel_e;

    typedef enum logic [1:0] {
        BUS_IDLE, BUS_RESP_OK, BUS_RESP_ERR
    } bus_st_e;

    function automatic reg_sel_e offset_to_sel(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_DESC:  s = REG_DESC;
            OFS_BUF:   s = REG_BUF;
            OFS_GRP:   s = REG_GRP;
            OFS_GRPDN: s = REG_GRPDN;
            OFS_CMD:   s = REG_CMD;
            OFS_CFG:   s = REG_CFG;
            OFS_STAT:  s = REG_STAT;
            OFS_IMASK: s = REG_IMASK;
            OFS_IACK:  s = REG_IACK;
            OFS_IRAW:  s = REG_IRAW;
            OFS_IMSKD: s = REG_IMSKD;
            OFS_STRM:  s = REG_STRM;
            default:   s = REG_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [3:0]              be_i,
    output logic [ADDR_W-OFS_W-1:0] ch_o,
    output reg_sel_e                sel_o,
    output logic                    ok_o
);
    localparam int CHF_W = ADDR_W - OFS_W;
    localparam logic [CHF_W:0] CH_LIMIT = (CHF_W+1)'(NUM_CH);

    logic full_word;
    logic ch_in_range;

    always_comb begin
        ch_o        = addr_i[ADDR_W-1:OFS_W];
        sel_o       = offset_to_sel(addr_i[OFS_W-1:0]);
        full_word   = (be_i == 4'hF);
        ch_in_range = ({1'b0, ch_o} < CH_LIMIT);
        ok_o        = full_word && ch_in_range;
    end

endmodule

// File: rtl/dma_rf_bus_fsm.sv
module dma_rf_bus_fsm
    import dma_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ok_i,
    output logic accept_o,
    output logic resp_valid_o,
    output logic resp_err_o
);
    bus_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:     if (req_i) state_d = ok_i ? BUS_RESP_OK : BUS_RESP_ERR;
            BUS_RESP_OK:  state_d = BUS_IDLE;
            BUS_RESP_ERR: state_d = BUS_IDLE;
            default:      state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o     = (state_q == BUS_IDLE) && req_i;
        resp_valid_o = (state_q != BUS_IDLE);
        resp_err_o   = (state_q == BUS_RESP_ERR);
    end

    assert_resp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !resp_valid_o);

    assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> resp_valid_o);

endmodule

// File: rtl/dma_rf_channel.sv
module dma_rf_channel
    import dma_rf_pkg::*;
#(
    parameter int INTR_W = 4,
    parameter int SRC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [31:0]       wdata_i,
    input  logic              client_attached_i,
    input  logic [2:0]        eng_state_i,
    input  logic              eng_eol_i,
    input  logic [SRC_W-1:0]  eng_src_i,
    input  logic [INTR_W-1:0] intr_set_i,
    input  logic              ctx_upd_i,
    input  logic [31:0]       ctx_desc_i,
    input  logic [31:0]       ctx_buf_i,
    output logic [31:0]       rd_o,
    output logic              chan_en_o,
    output logic              chan_stop_o,
    output logic              load_d_o,
    output logic              load_c_o,
    output logic              start_o,
    output logic              cont_o,
    output logic              irq_o,
    output logic [31:0]       desc_o,
    output logic [31:0]       buf_o,
    output logic [31:0]       grp_o,
    output logic [31:0]       grp_down_o
);
    localparam int STAT_PAD = 24 - SRC_W;
    localparam int IPAD     = 32 - INTR_W;

    logic [31:0]       desc_q, buf_q, grp_q, grpdn_q, cmd_q, cfg_q, strm_q;
    logic [INTR_W-1:0] mask_q, raw_q, masked_q;
    logic [INTR_W-1:0] raw_d, mask_d, ack_bits;
    logic [9:0]        cmd10;
    logic              strm_wr, cmd_wr, wants_load_d;
    logic              ld_d_q, ld_c_q, st_q, cont_q;
    logic [31:0]       stat_word;

    always_comb begin
        strm_wr      = wr_en_i && (sel_i == REG_STRM);
        cmd_wr       = wr_en_i && (sel_i == REG_CMD);
        cmd10        = wdata_i[9:0];
        wants_load_d = |(cmd10 & STRM_LOAD_D);
        ack_bits     = (wr_en_i && sel_i == REG_IACK) ? wdata_i[INTR_W-1:0] : '0;
        raw_d        = (raw_q & ~ack_bits) | intr_set_i;
        mask_d       = (wr_en_i && sel_i == REG_IMASK) ? wdata_i[INTR_W-1:0] : mask_q;
    end

    // pointer and configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q  <= '0;
            buf_q   <= '0;
            grp_q   <= '0;
            grpdn_q <= '0;
            cmd_q   <= '0;
            cfg_q   <= '0;
            strm_q  <= '0;
        end else begin
            if (wr_en_i) begin
                unique case (sel_i)
                    REG_DESC:  desc_q  <= wdata_i;
                    REG_BUF:   buf_q   <= wdata_i;
                    REG_GRP:   grp_q   <= wdata_i;
                    REG_GRPDN: grpdn_q <= wdata_i;
                    REG_CMD:   cmd_q   <= wdata_i;
                    REG_CFG:   cfg_q   <= wdata_i;
                    REG_STRM:  strm_q  <= wdata_i;
                    default:   ;
                endcase
            end
            if (ctx_upd_i) begin
                desc_q <= ctx_desc_i;
                buf_q  <= ctx_buf_i;
            end
        end
    end

    // interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q    <= '0;
            mask_q   <= '0;
            masked_q <= '0;
        end else begin
            raw_q    <= raw_d;
            mask_q   <= mask_d;
            masked_q <= raw_d & mask_d;
        end
    end

    // command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_d_q <= 1'b0;
            ld_c_q <= 1'b0;
            st_q   <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            ld_d_q <= strm_wr && wants_load_d;
            st_q   <= strm_wr && wants_load_d && cmd10[STRM_BURST];
            ld_c_q <= strm_wr && cmd10[STRM_LOAD_C];
            cont_q <= cmd_wr;
        end
    end

    always_comb begin
        stat_word = {{STAT_PAD{1'b0}}, eng_src_i, 2'b00, eng_eol_i, 2'b00, eng_state_i};
        unique case (sel_i)
            REG_DESC:  rd_o = desc_q;
            REG_BUF:   rd_o = buf_q;
            REG_GRP:   rd_o = grp_q;
            REG_GRPDN: rd_o = grpdn_q;
            REG_CMD:   rd_o = cmd_q;
            REG_CFG:   rd_o = cfg_q;
            REG_STAT:  rd_o = stat_word;
            REG_IMASK: rd_o = {{IPAD{1'b0}}, mask_q};
            REG_IRAW:  rd_o = {{IPAD{1'b0}}, raw_q};
            REG_IMSKD: rd_o = {{IPAD{1'b0}}, masked_q};
            REG_STRM:  rd_o = strm_q;
            default:   rd_o = '0;
        endcase
    end

    always_comb begin
        chan_en_o   = cfg_q[0] && client_attached_i;
        chan_stop_o = cfg_q[1];
        load_d_o    = ld_d_q;
        load_c_o    = ld_c_q;
        start_o     = st_q;
        cont_o      = cont_q;
        irq_o       = |masked_q;
        desc_o      = desc_q;
        buf_o       = buf_q;
        grp_o       = grp_q;
        grp_down_o  = grpdn_q;
    end

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == REG_IACK && intr_set_i == '0)
        |=> ((raw_q & $past(wdata_i[INTR_W-1:0])) == '0));

    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(raw_q & mask_q)));

    assert_start_with_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> load_d_o);

    assert_cont_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |=> !cont_o);

    assert_ctx_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_upd_i |=> (desc_o == $past(ctx_desc_i)) && (buf_o == $past(ctx_buf_i)));

endmodule

// File: rtl/dma_chan_regfront.sv
module dma_chan_regfront
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    parameter int INTR_W = 4,
    parameter int SRC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [3:0]               be_i,
    input  logic [31:0]              wdata_i,
    output logic                     resp_valid_o,
    output logic                     resp_err_o,
    output logic [31:0]              rdata_o,
    input  logic [NUM_CH-1:0]        client_attached_i,
    input  logic [NUM_CH*3-1:0]      eng_state_i,
    input  logic [NUM_CH-1:0]        eng_eol_i,
    input  logic [NUM_CH*SRC_W-1:0]  eng_src_i,
    input  logic [NUM_CH*INTR_W-1:0] intr_set_i,
    input  logic [NUM_CH-1:0]        ctx_upd_i,
    input  logic [NUM_CH*32-1:0]     ctx_desc_i,
    input  logic [NUM_CH*32-1:0]     ctx_buf_i,
    output logic [NUM_CH-1:0]        chan_en_o,
    output logic [NUM_CH-1:0]        chan_stop_o,
    output logic [NUM_CH-1:0]        load_d_o,
    output logic [NUM_CH-1:0]        load_c_o,
    output logic [NUM_CH-1:0]        start_o,
    output logic [NUM_CH-1:0]        cont_o,
    output logic [NUM_CH-1:0]        irq_o,
    output logic [NUM_CH*32-1:0]     desc_o,
    output logic [NUM_CH*32-1:0]     buf_o,
    output logic [NUM_CH*32-1:0]     grp_o,
    output logic [NUM_CH*32-1:0]     grp_down_o
);
    localparam int CHF_W = ADDR_W - OFS_W;

    logic [CHF_W-1:0] ch_idx;
    reg_sel_e         sel;
    logic             acc_ok, accept;
    logic [31:0]      rd_ch [NUM_CH];
    logic [31:0]      rd_pick;
    logic [31:0]      rdata_q;

    dma_rf_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr_i (addr_i),
        .be_i   (be_i),
        .ch_o   (ch_idx),
        .sel_o  (sel),
        .ok_o   (acc_ok)
    );

    dma_rf_bus_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .ok_i         (acc_ok),
        .accept_o     (accept),
        .resp_valid_o (resp_valid_o),
        .resp_err_o   (resp_err_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_en;
        assign wr_en = accept && acc_ok && we_i && (ch_idx == CHF_W'(i));

        dma_rf_channel #(.INTR_W(INTR_W), .SRC_W(SRC_W)) u_ch (
            .clk               (clk),
            .rst_n             (rst_n),
            .wr_en_i           (wr_en),
            .sel_i             (sel),
            .wdata_i           (wdata_i),
            .client_attached_i (client_attached_i[i]),
            .eng_state_i       (eng_state_i[i*3 +: 3]),
            .eng_eol_i         (eng_eol_i[i]),
            .eng_src_i         (eng_src_i[i*SRC_W +: SRC_W]),
            .intr_set_i        (intr_set_i[i*INTR_W +: INTR_W]),
            .ctx_upd_i         (ctx_upd_i[i]),
            .ctx_desc_i        (ctx_desc_i[i*32 +: 32]),
            .ctx_buf_i         (ctx_buf_i[i*32 +: 32]),
            .rd_o              (rd_ch[i]),
            .chan_en_o         (chan_en_o[i]),
            .chan_stop_o       (chan_stop_o[i]),
            .load_d_o          (load_d_o[i]),
            .load_c_o          (load_c_o[i]),
            .start_o           (start_o[i]),
            .cont_o            (cont_o[i]),
            .irq_o             (irq_o[i]),
            .desc_o            (desc_o[i*32 +: 32]),
            .buf_o             (buf_o[i*32 +: 32]),
            .grp_o             (grp_o[i*32 +: 32]),
            .grp_down_o        (grp_down_o[i*32 +: 32])
        );
    end

    always_comb begin
        rd_pick = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CHF_W'(i)) rd_pick = rd_ch[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= (acc_ok && !we_i) ? rd_pick : '0;
    end

    assign rdata_o = rdata_q;

    assert_narrow_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && be_i != 4'hF) |=> (resp_err_o && rdata_o == '0));

    assert_err_only_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_ok) |=> !resp_err_o);

endmodule

// File: tb/sim_dma_chan_regfront.sv
`timescale 1ns/1ps
module sim_dma_chan_regfront;
    localparam int NC = 2;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int SW = 8;

    logic clk = 0, rst_n = 0;
    logic req = 0, we = 0;
    logic [AW-1:0] addr = '0;
    logic [3:0] be = 4'hF;
    logic [31:0] wdata = '0;
    logic resp_valid, resp_err;
    logic [31:0] rdata;
    logic [NC-1:0] client = '0;
    logic [NC*3-1:0] eng_state = '0;
    logic [NC-1:0] eng_eol = '0;
    logic [NC*SW-1:0] eng_src = '0;
    logic [NC*IW-1:0] iset = '0;
    logic [NC-1:0] ctx_upd = '0;
    logic [NC*32-1:0] ctx_desc = '0, ctx_buf = '0;
    logic [NC-1:0] chan_en, chan_stop, load_d, load_c, start, cont, irq;
    logic [NC*32-1:0] desc, bufp, grp, grpdn;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [NC-1:0] c_ld, c_lc, c_st, c_ct, c_irq;
    logic [31:0] r_data;
    logic r_err, r_valid;

    always #4 clk = ~clk;

    dma_chan_regfront #(.NUM_CH(NC), .ADDR_W(AW), .INTR_W(IW), .SRC_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
        .wdata_i(wdata), .resp_valid_o(resp_valid), .resp_err_o(resp_err), .rdata_o(rdata),
        .client_attached_i(client), .eng_state_i(eng_state), .eng_eol_i(eng_eol),
        .eng_src_i(eng_src), .intr_set_i(iset), .ctx_upd_i(ctx_upd), .ctx_desc_i(ctx_desc),
        .ctx_buf_i(ctx_buf), .chan_en_o(chan_en), .chan_stop_o(chan_stop), .load_d_o(load_d),
        .load_c_o(load_c), .start_o(start), .cont_o(cont), .irq_o(irq), .desc_o(desc),
        .buf_o(bufp), .grp_o(grp), .grp_down_o(grpdn)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one access: drive on a falling edge, sample response on the next one
    task automatic access(input int ch, input logic [12:0] ofs, input logic w,
                          input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        req = 1; we = w; addr = {3'(ch), ofs}; wdata = d; be = b;
        @(negedge clk);
        r_valid = resp_valid; r_err = resp_err; r_data = rdata;
        c_ld = load_d; c_lc = load_c; c_st = start; c_ct = cont; c_irq = irq;
        req = 0; we = 0; be = 4'hF;
        check("R1 resp_valid", {31'b0, r_valid}, 32'd1);
    endtask

    task automatic wr(input int ch, input logic [12:0] ofs, input logic [31:0] d);
        access(ch, ofs, 1'b1, d, 4'hF);
    endtask

    task automatic rd(input int ch, input logic [12:0] ofs, output logic [31:0] d);
        access(ch, ofs, 1'b0, 32'h0, 4'hF);
        d = r_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R6 irq after reset", {30'b0, irq}, 32'd0);
        check("R4 chan_en after reset", {30'b0, chan_en}, 32'd0);
        check("R1 no resp after reset", {31'b0, resp_valid}, 32'd0);
        rd(0, 13'h084, v);
        check("R2 cfg reset value", v, 32'd0);
    endtask

    task automatic t_storage;
        logic [31:0] v;
        wr(0, 13'h060, 32'hA000_0060); wr(0, 13'h07C, 32'hB000_007C);
        wr(0, 13'h058, 32'hC000_0058); wr(0, 13'h05C, 32'hD000_005C);
        wr(1, 13'h060, 32'h1111_2222);
        rd(0, 13'h060, v); check("R2 group", v, 32'hA000_0060);
        rd(0, 13'h07C, v); check("R2 group-down", v, 32'hB000_007C);
        rd(0, 13'h058, v); check("R2 saved desc", v, 32'hC000_0058);
        rd(0, 13'h05C, v); check("R2 buf ptr", v, 32'hD000_005C);
        rd(1, 13'h060, v); check("R2 group ch1", v, 32'h1111_2222);
        check("R2 grp_o ch0", grp[31:0], 32'hA000_0060);
        wr(0, 13'h040, 32'hFFFF_FFFF);
        rd(0, 13'h040, v); check("R2 unmapped reads 0", v, 32'd0);
        wr(0, 13'h08C, 32'hFFFF_FFFF);
        rd(0, 13'h08C, v); check("R2 mask width", v, 32'h0000_000F);
        wr(0, 13'h08C, 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] v;
        eng_state[5:3] = 3'd4; eng_eol[1] = 1'b1; eng_src[15:8] = 8'hA5;
        rd(1, 13'h088, v); check("R3 status running", v, 32'h0000_A524);
        wr(1, 13'h088, 32'hFFFF_FFFF);
        eng_state[5:3] = 3'd2; eng_eol[1] = 1'b0;
        rd(1, 13'h088, v); check("R3 status stopped, write ignored", v, 32'h0000_A502);
    endtask

    task automatic t_cfg;
        client[0] = 1'b0;
        wr(0, 13'h084, 32'h1);
        check("R4 enable needs client", {31'b0, chan_en[0]}, 32'd0);
        client[0] = 1'b1; #1;
        check("R4 enable with client", {31'b0, chan_en[0]}, 32'd1);
        wr(0, 13'h084, 32'h2);
        check("R4 stop bit", {31'b0, chan_stop[0]}, 32'd1);
        check("R4 enable cleared", {31'b0, chan_en[0]}, 32'd0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        @(negedge clk); iset[3:0] = 4'b0100;
        @(negedge clk); iset = '0;
        check("R6 masked off irq low", {31'b0, irq[0]}, 32'd0);
        rd(0, 13'h094, v); check("R6 raw set", v, 32'h4);
        rd(0, 13'h098, v); check("R6 masked zero", v, 32'h0);
        wr(0, 13'h08C, 32'h4);
        check("R6 irq after mask", {31'b0, c_irq[0]}, 32'd1);
        check("R6 other channel quiet", {31'b0, c_irq[1]}, 32'd0);
        rd(0, 13'h098, v); check("R6 masked value", v, 32'h4);
        wr(0, 13'h090, 32'h4);
        check("R5 irq after ack", {31'b0, c_irq[0]}, 32'd0);
        rd(0, 13'h094, v); check("R5 raw cleared", v, 32'h0);
        rd(0, 13'h090, v); check("R5 ack reads 0", v, 32'h0);
        // ack and set of the same bit in one cycle: set wins
        @(negedge clk); iset[3:0] = 4'b0100;
        @(negedge clk); iset = '0;
        @(negedge clk);
        req = 1; we = 1; addr = {3'd0, 13'h090}; wdata = 32'h4; iset[3:0] = 4'b0100;
        @(negedge clk); req = 0; we = 0; iset = '0;
        rd(0, 13'h094, v); check("R5 set beats ack", v, 32'h4);
        check("R6 irq stays high", {31'b0, irq[0]}, 32'd1);
        wr(0, 13'h090, 32'hF);
        wr(0, 13'h08C, 32'h0);
    endtask

    task automatic t_stream;
        logic [31:0] v;
        wr(0, 13'h09C, 32'h040);
        check("R7 bit6 load_d", {31'b0, c_ld[0]}, 32'd1);
        check("R7 bit6 no start", {31'b0, c_st[0]}, 32'd0);
        check("R7 bit6 no load_c", {31'b0, c_lc[0]}, 32'd0);
        @(negedge clk);
        check("R7 pulse one cycle", {31'b0, load_d[0]}, 32'd0);
        wr(1, 13'h09C, 32'h120);
        check("R7 bit8+5 load_d", {31'b0, c_ld[1]}, 32'd1);
        check("R7 bit8+5 start", {31'b0, c_st[1]}, 32'd1);
        check("R7 ch0 unaffected", {31'b0, c_ld[0]}, 32'd0);
        wr(0, 13'h09C, 32'h200);
        check("R7 bit9 load_c", {31'b0, c_lc[0]}, 32'd1);
        check("R7 bit9 no load_d", {31'b0, c_ld[0]}, 32'd0);
        wr(0, 13'h09C, 32'h420);
        check("R7 high bits ignored", {29'b0, c_ld[0], c_st[0], c_lc[0]}, 32'd0);
        rd(0, 13'h09C, v); check("R2 stream reg readback", v, 32'h420);
    endtask

    task automatic t_cmd;
        logic [31:0] v;
        wr(1, 13'h080, 32'h1);
        check("R9 continue pulse", {31'b0, c_ct[1]}, 32'd1);
        @(negedge clk);
        check("R9 continue ends", {31'b0, cont[1]}, 32'd0);
        rd(1, 13'h080, v); check("R2 command readback", v, 32'h1);
    endtask

    task automatic t_ctx;
        logic [31:0] v;
        @(negedge clk);
        ctx_upd[1] = 1; ctx_desc[63:32] = 32'h5555_0000; ctx_buf[63:32] = 32'h6666_0000;
        @(negedge clk); ctx_upd = '0;
        rd(1, 13'h058, v); check("R8 ctx desc", v, 32'h5555_0000);
        rd(1, 13'h05C, v); check("R8 ctx buf", v, 32'h6666_0000);
        @(negedge clk);
        req = 1; we = 1; addr = {3'd1, 13'h058}; wdata = 32'hDEAD_BEEF;
        ctx_upd[1] = 1; ctx_desc[63:32] = 32'h7777_0000;
        @(negedge clk); req = 0; we = 0; ctx_upd = '0;
        rd(1, 13'h058, v); check("R8 ctx beats bus", v, 32'h7777_0000);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        access(0, 13'h060, 1'b1, 32'h0BAD_0BAD, 4'h3);
        check("R10 narrow write err", {31'b0, r_err}, 32'd1);
        rd(0, 13'h060, v); check("R10 narrow write dropped", v, 32'hA000_0060);
        access(0, 13'h060, 1'b0, 32'h0, 4'h1);
        check("R10 narrow read err", {31'b0, r_err}, 32'd1);
        check("R10 narrow read data 0", r_data, 32'd0);
        access(2, 13'h060, 1'b0, 32'h0, 4'hF);
        check("R1 channel out of range err", {31'b0, r_err}, 32'd1);
        access(1, 13'h060, 1'b0, 32'h0, 4'hF);
        check("R1 legal access ok", {31'b0, r_err}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_storage();
        t_status();
        t_cfg();
        t_irq();
        t_stream();
        t_cmd();
        t_ctx();
        t_errors();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule